// File: doc/BRIEF.md
# Nibble-Wide Double-Edge Link Receiver

This block is the receiving end of a point-to-point serial link that carries four data bits per clock transition. The transmitter toggles a link clock and presents a new nibble with every toggle, so each rising and each falling transition of the link clock delivers one nibble. The receiver samples the link clock, data and block-complete lines in its own system clock domain. It detects every transition, packs 32 nibbles least-significant first into a 128-bit quad-word, and stores finished quad-words in a three-slot buffer. A core or DMA engine drains that buffer over a ready/valid port.

Flow control goes back to the transmitter on an acknowledge line. The line drops as soon as two slots hold data, which leaves one free slot for a quad-word that is already on the wire. A quad-word that finds all three slots full is dropped, and this is recorded. A rising edge on the block-complete input closes the current block. If fewer quad-words than the programmed block length arrived, a length error is recorded. When checksum checking is on, the quad-word that follows the programmed number of data quad-words is consumed as a checksum and is not stored. Its low 16 bits must equal the byte sum of the block's data. All three error flags are sticky until a clear pulse.

Top module: `nib_link_rx`

## Requirements
- R1: While rst_ni is low and right after it is released, qw_valid_o is 0, ack_o is 1 and sum_err_o, len_err_o and ovf_o are 0.
- R2: One nibble is taken from ldat_i on every rising and every falling transition of lclk_i. Nibble k (k = 0..31) of a quad-word lands in bits [4k+3:4k], and the 32nd nibble completes the quad-word.
- R3: Stored quad-words leave in arrival order. qw_data_o shows the oldest one whenever qw_valid_o is 1, and a word is removed on a clock where qw_valid_o and qw_ready_i are both 1.
- R4: ack_o is 0 while two or three slots are occupied and 1 while zero or one slot is occupied.
- R5: A completed quad-word that is due for storage while all three slots are full is discarded, even if a read happens on the same clock, and ovf_o is set and stays set.
- R6: With chk_en_i = 1, the quad-word numbered blk_len_i (counted from 0 since the last block end) is not stored. Its bits [15:0] are compared with the sum modulo 2^16 of all 16 bytes of each of the blk_len_i data quad-words before it. On a mismatch, sum_err_o is set and stays set.
- R7: With chk_en_i = 0 every completed quad-word is stored and sum_err_o is never set.
- R8: A rising edge of bcmp_i when fewer than blk_len_i quad-words (blk_len_i + 1 with chk_en_i = 1) have completed in the block sets len_err_o, which stays set.
- R9: A rising edge of bcmp_i ends the block: nibbles of an unfinished quad-word are discarded, and quad-word counting and the byte sum restart from zero.
- R10: A one-clock pulse on err_clr_i clears sum_err_o, len_err_o and ovf_o on the next clock edge.
- R11: A stored quad-word becomes visible on qw_valid_o and qw_data_o three system clock edges after the edge that first samples its final lclk_i transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lclk_i | input | 1 | Link clock from the transmitter; each transition carries a nibble |
| ldat_i | input | 4 | Link data nibble |
| bcmp_i | input | 1 | Block-complete from the transmitter; rising edge ends a block |
| ack_o | output | 1 | Flow-control acknowledge to the transmitter |
| chk_en_i | input | 1 | Enables checksum checking of received blocks |
| blk_len_i | input | 8 | Number of data quad-words per block |
| err_clr_i | input | 1 | Clears all sticky error flags |
| qw_data_o | output | 128 | Oldest stored quad-word |
| qw_valid_o | output | 1 | A stored quad-word is available |
| qw_ready_i | input | 1 | Consumer takes the word on qw_data_o |
| sum_err_o | output | 1 | Sticky checksum mismatch flag |
| len_err_o | output | 1 | Sticky short-block flag |
| ovf_o | output | 1 | Sticky dropped-quad-word flag |

## Verification
The bench fills the buffer without draining it. A design that compares against the wrong occupancy either keeps acknowledge high into overflow or drops it after one word, and a design that lets a concurrent read rescue a full buffer stores the fourth word. Checksum blocks are sent with correct and with corrupted sums, and the same block is repeated with checking off. A design that stores the checksum word, or that sums the wrong bytes, gives a different buffer content or flag. The bench also sends a short block and a block cut off mid-word ahead of a full word. A receiver that keeps stale nibbles across a block end misplaces every later nibble, and one that keeps stale counts misses the length error. The first word's exact arrival cycle is checked as well, so an extra or missing pipeline stage is caught.

// File: rtl/nlr_pkg.sv
package nlr_pkg;
  localparam int NIB_W_DEF = 4;
  localparam int QW_W_DEF  = 128;
  localparam int DEPTH_DEF = 3;
  localparam int LEN_W_DEF = 8;
  localparam int SUM_W_DEF = 16;
endpackage

// File: rtl/nlr_sample.sv
module nlr_sample #(
  parameter int NIB_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lclk_i,
  input  logic [NIB_W-1:0] ldat_i,
  input  logic             bcmp_i,
  output logic             tog_o,
  output logic [NIB_W-1:0] nib_o,
  output logic             eob_o
);
  logic             lclk_q, lclk_q2, bcmp_q, bcmp_q2;
  logic [NIB_W-1:0] dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lclk_q  <= 1'b0;
      lclk_q2 <= 1'b0;
      bcmp_q  <= 1'b0;
      bcmp_q2 <= 1'b0;
      dat_q   <= '0;
    end else begin
      lclk_q  <= lclk_i;
      lclk_q2 <= lclk_q;
      bcmp_q  <= bcmp_i;
      bcmp_q2 <= bcmp_q;
      dat_q   <= ldat_i;
    end
  end

  // either transition of the link clock carries a nibble
  assign tog_o = lclk_q ^ lclk_q2;
  assign nib_o = dat_q;
  assign eob_o = bcmp_q & ~bcmp_q2;
endmodule

// File: rtl/nlr_asm.sv
module nlr_asm #(
  parameter int NIB_W = 4,
  parameter int QW_W  = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tog_i,
  input  logic [NIB_W-1:0] nib_i,
  input  logic             eob_i,
  output logic             push_o,
  output logic [QW_W-1:0]  qw_o,
  output logic             eob_o
);
  localparam int NIBS = QW_W / NIB_W;
  localparam int CW   = $clog2(NIBS);
  localparam logic [CW-1:0] LAST = CW'(NIBS - 1);

  logic [CW-1:0]   cnt_q;
  logic [QW_W-1:0] sh_q, sh_nxt;

  always_comb begin
    sh_nxt = sh_q;
    sh_nxt[cnt_q*NIB_W +: NIB_W] = nib_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      push_o <= 1'b0;
      qw_o   <= '0;
      eob_o  <= 1'b0;
    end else begin
      eob_o  <= eob_i;
      push_o <= 1'b0;
      if (eob_i) begin
        cnt_q <= '0;
      end else if (tog_i) begin
        sh_q <= sh_nxt;
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          push_o <= 1'b1;
          qw_o   <= sh_nxt;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  a_r2_push_follows_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> $past(tog_i));
endmodule

// File: rtl/nlr_fifo.sv
module nlr_fifo #(
  parameter int W       = 128,
  parameter int DEPTH   = 3,
  parameter int ACK_LVL = DEPTH - 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  output logic [W-1:0] rdata_o,
  output logic         valid_o,
  output logic         ack_o,
  output logic         drop_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] PLAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          full, wr_ok, rd_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign wr_ok   = wr_i & ~full;
  assign rd_ok   = rd_i & (cnt_q != '0);
  assign drop_o  = wr_i & full;
  assign valid_o = (cnt_q != '0);
  assign rdata_o = mem[rp_q];
  assign ack_o   = (cnt_q < CW'(ACK_LVL));

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ok) wp_q <= (wp_q == PLAST) ? '0 : wp_q + 1'b1;
      if (rd_ok) rp_q <= (rp_q == PLAST) ? '0 : rp_q + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r3_read_drains: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && valid_o && !wr_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r4_ack_falls_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_o) |-> $past(wr_i));
  a_r5_drop_only_when_throttled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> !ack_o);
endmodule

// File: rtl/nlr_blk_chk.sv
module nlr_blk_chk #(
  parameter int QW_W  = 128,
  parameter int LEN_W = 8,
  parameter int SUM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [QW_W-1:0]  qw_i,
  input  logic             eob_i,
  input  logic             chk_en_i,
  input  logic [LEN_W-1:0] blk_len_i,
  input  logic             err_clr_i,
  input  logic             drop_i,
  output logic             wr_o,
  output logic             sum_err_o,
  output logic             len_err_o,
  output logic             ovf_o
);
  localparam int NB = QW_W / 8;

  logic [LEN_W:0]   qcnt_q, len_ext, need;
  logic [SUM_W-1:0] sum_q, bsum;
  logic             is_ck, mism, short_blk;

  always_comb begin
    bsum = '0;
    for (int i = 0; i < NB; i++) bsum = bsum + SUM_W'(qw_i[i*8 +: 8]);
  end

  assign len_ext   = {1'b0, blk_len_i};
  assign need      = len_ext + (LEN_W+1)'(chk_en_i);
  assign is_ck     = chk_en_i && (qcnt_q == len_ext);
  assign wr_o      = push_i && !is_ck;
  assign mism      = push_i && is_ck && (qw_i[SUM_W-1:0] != sum_q);
  assign short_blk = eob_i && (qcnt_q < need);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qcnt_q <= '0;
      sum_q  <= '0;
    end else if (eob_i) begin
      qcnt_q <= '0;
      sum_q  <= '0;
    end else if (push_i) begin
      if (qcnt_q < len_ext) sum_q <= sum_q + bsum;
      if (qcnt_q != '1) qcnt_q <= qcnt_q + 1'b1;
    end
  end

  // set wins over a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_err_o <= 1'b0;
      len_err_o <= 1'b0;
      ovf_o     <= 1'b0;
    end else begin
      sum_err_o <= (sum_err_o & ~err_clr_i) | mism;
      len_err_o <= (len_err_o & ~err_clr_i) | short_blk;
      ovf_o     <= (ovf_o & ~err_clr_i) | drop_i;
    end
  end

  a_r6_sum_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_err_o && !err_clr_i) |=> sum_err_o);
  a_r8_len_err_at_block_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(len_err_o) |-> $past(eob_i));
  a_r5_ovf_from_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(drop_i));
  a_r10_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_clr_i && !eob_i && !push_i && !drop_i) |=> (!sum_err_o && !len_err_o && !ovf_o));
endmodule

// File: rtl/nib_link_rx.sv
module nib_link_rx #(
  parameter int NIB_W = nlr_pkg::NIB_W_DEF,
  parameter int QW_W  = nlr_pkg::QW_W_DEF,
  parameter int DEPTH = nlr_pkg::DEPTH_DEF,
  parameter int LEN_W = nlr_pkg::LEN_W_DEF,
  parameter int SUM_W = nlr_pkg::SUM_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lclk_i,
  input  logic [NIB_W-1:0] ldat_i,
  input  logic             bcmp_i,
  output logic             ack_o,
  input  logic             chk_en_i,
  input  logic [LEN_W-1:0] blk_len_i,
  input  logic             err_clr_i,
  output logic [QW_W-1:0]  qw_data_o,
  output logic             qw_valid_o,
  input  logic             qw_ready_i,
  output logic             sum_err_o,
  output logic             len_err_o,
  output logic             ovf_o
);
  localparam int ACK_LVL = DEPTH - 1;

  logic             tog, eob_s, push, eob_a, wr, drop;
  logic [NIB_W-1:0] nib;
  logic [QW_W-1:0]  qw;

  nlr_sample #(.NIB_W(NIB_W)) u_sample (
    .clk_i, .rst_ni, .lclk_i, .ldat_i, .bcmp_i,
    .tog_o(tog), .nib_o(nib), .eob_o(eob_s)
  );

  nlr_asm #(.NIB_W(NIB_W), .QW_W(QW_W)) u_asm (
    .clk_i, .rst_ni, .tog_i(tog), .nib_i(nib), .eob_i(eob_s),
    .push_o(push), .qw_o(qw), .eob_o(eob_a)
  );

  nlr_blk_chk #(.QW_W(QW_W), .LEN_W(LEN_W), .SUM_W(SUM_W)) u_chk (
    .clk_i, .rst_ni, .push_i(push), .qw_i(qw), .eob_i(eob_a),
    .chk_en_i, .blk_len_i, .err_clr_i, .drop_i(drop),
    .wr_o(wr), .sum_err_o, .len_err_o, .ovf_o
  );

  nlr_fifo #(.W(QW_W), .DEPTH(DEPTH), .ACK_LVL(ACK_LVL)) u_fifo (
    .clk_i, .rst_ni, .wr_i(wr), .wdata_i(qw), .rd_i(qw_ready_i),
    .rdata_o(qw_data_o), .valid_o(qw_valid_o), .ack_o, .drop_o(drop)
  );
endmodule

// File: tb/nib_link_rx_tb.sv
`timescale 1ns/1ps
module nib_link_rx_tb;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         lclk = 1'b0, bcmp = 1'b0, chk_en = 1'b0, err_clr = 1'b0, rdy = 1'b0;
  logic [3:0]   ldat = '0;
  logic [7:0]   blk_len = 8'd2;
  logic         ack, valid, sum_err, len_err, ovf;
  logic [127:0] qdata;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nib_link_rx u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .lclk_i(lclk), .ldat_i(ldat), .bcmp_i(bcmp),
    .ack_o(ack), .chk_en_i(chk_en), .blk_len_i(blk_len), .err_clr_i(err_clr),
    .qw_data_o(qdata), .qw_valid_o(valid), .qw_ready_i(rdy),
    .sum_err_o(sum_err), .len_err_o(len_err), .ovf_o(ovf)
  );

  // reference model state
  logic         h_lclk [4];
  logic         h_bcmp [4];
  logic [3:0]   h_dat  [4];
  logic [127:0] mq [$];
  logic [127:0] m_asm;
  int           m_nc, m_qc, m_sum;
  bit           m_sum_err, m_len_err, m_ovf;

  function automatic int bsum(input logic [127:0] w);
    int s = 0;
    for (int i = 0; i < 16; i++) s += int'(w[i*8 +: 8]);
    return s & 16'hFFFF;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      h_lclk[i] = 1'b0; h_bcmp[i] = 1'b0; h_dat[i] = '0;
    end
    mq.delete();
    m_asm = '0; m_nc = 0; m_qc = 0; m_sum = 0;
    m_sum_err = 0; m_len_err = 0; m_ovf = 0;
  endtask

  task automatic tick();
    int  pre;
    bit  tg, eb;
    @(negedge clk);
    for (int i = 3; i > 0; i--) begin
      h_lclk[i] = h_lclk[i-1]; h_bcmp[i] = h_bcmp[i-1]; h_dat[i] = h_dat[i-1];
    end
    h_lclk[0] = lclk; h_bcmp[0] = bcmp; h_dat[0] = ldat;
    if (!rst_ni) return;
    pre = mq.size();
    if (err_clr) begin m_sum_err = 0; m_len_err = 0; m_ovf = 0; end
    tg = (h_lclk[2] != h_lclk[3]);
    eb = h_bcmp[2] && !h_bcmp[3];
    if (eb) begin
      if (m_qc < int'(blk_len) + int'(chk_en)) m_len_err = 1;
      m_qc = 0; m_sum = 0; m_nc = 0;
    end else if (tg) begin
      m_asm[m_nc*4 +: 4] = h_dat[2];
      if (m_nc == 31) begin
        m_nc = 0;
        if (chk_en && m_qc == int'(blk_len)) begin
          if (int'(m_asm[15:0]) != m_sum) m_sum_err = 1;
        end else begin
          if (m_qc < int'(blk_len)) m_sum = (m_sum + bsum(m_asm)) & 16'hFFFF;
          if (pre == 3) m_ovf = 1;
          else mq.push_back(m_asm);
        end
        m_qc++;
      end else m_nc++;
    end
    if (rdy && pre > 0) void'(mq.pop_front());
    chk("R3 valid", 128'(valid), 128'(mq.size() > 0));
    if (mq.size() > 0) chk("R2 data", qdata, mq[0]);
    chk("R4 ack", 128'(ack), 128'(mq.size() < 2));
    chk("R6 sum_err", 128'(sum_err), 128'(m_sum_err));
    chk("R8 len_err", 128'(len_err), 128'(m_len_err));
    chk("R5 ovf", 128'(ovf), 128'(m_ovf));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic send_nibs(input logic [127:0] q, input int n);
    for (int k = 0; k < n; k++) begin
      lclk = ~lclk;
      ldat = q[k*4 +: 4];
      tick();
      if (k != n - 1) tick();
    end
  endtask

  task automatic end_block();
    bcmp = 1'b1; idle(3);
    bcmp = 1'b0; idle(5);
  endtask

  task automatic clear();
    err_clr = 1'b1; tick();
    err_clr = 1'b0; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] qa, qb, qc, qd, qe, qf, qg, qh;
    qa = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
    qb = 128'h11223344_55667788_99AABBCC_DDEEFF00;
    qc = 128'hDEADBEEF_01234567_89ABCDEF_FEDCBA98;
    qd = 128'h13579BDF_2468ACE0_0ECA8642_FDB97531;
    qe = 128'hA5A5A5A5_5A5A5A5A_C3C3C3C3_3C3C3C3C;
    qf = 128'h00000001_00000002_00000003_00000004;
    qh = 128'h76543210_FEDCBA98_01020304_05060708;
    qg = {112'h9999_8888_7777_6666_5555_4444_3333, 16'((bsum(qe) + bsum(qf)) & 16'hFFFF)};

    model_reset();
    idle(3);
    // R1: reset state
    chk("R1 valid", 128'(valid), 128'd0);
    chk("R1 ack", 128'(ack), 128'd1);
    chk("R1 flags", 128'({sum_err, len_err, ovf}), 128'd0);
    rst_ni = 1'b1;
    idle(2);
    chk("R1 after release", 128'({valid, ack, sum_err, len_err, ovf}), 128'b01000);

    // fill without draining, checking off
    chk_en = 1'b0; blk_len = 8'd2; rdy = 1'b0;
    send_nibs(qa, 32);
    tick();
    chk("R11 not yet valid", 128'(valid), 128'd0);
    tick();
    chk("R11 valid at third edge", 128'(valid), 128'd1);
    chk("R2 first word", qdata, qa);
    send_nibs(qb, 32); idle(4);
    chk("R4 ack low at two", 128'(ack), 128'd0);
    send_nibs(qc, 32); idle(4);
    chk("R4 ack low at three", 128'(ack), 128'd0);
    // fourth word while full, read on the same clock does not rescue it
    send_nibs(qd, 31);
    lclk = ~lclk; ldat = qd[127:124]; tick(); tick();
    rdy = 1'b1; tick(); rdy = 1'b0;
    idle(3);
    chk("R5 ovf set", 128'(ovf), 128'd1);
    chk("R5 dropped word absent", qdata, qb);
    end_block();
    chk("R8 no len_err on full block", 128'(len_err), 128'd0);
    rdy = 1'b1; tick();
    chk("R3 order", qdata, qc);
    tick();
    chk("R3 drained", 128'(valid), 128'd0);
    idle(2);
    clear();
    chk("R10 ovf cleared", 128'(ovf), 128'd0);

    // checking on, correct checksum
    rdy = 1'b0; chk_en = 1'b1; blk_len = 8'd2;
    send_nibs(qe, 32); send_nibs(qf, 32); send_nibs(qg, 32); idle(4);
    chk("R6 good sum no error", 128'(sum_err), 128'd0);
    chk("R6 checksum not stored", 128'(ack), 128'd0);
    rdy = 1'b1; idle(2);
    chk("R6 only data stored", 128'(valid), 128'd0);
    rdy = 1'b0;
    end_block();
    chk("R8 full checked block", 128'(len_err), 128'd0);

    // checking on, corrupt checksum
    send_nibs(qe, 32); send_nibs(qf, 32);
    send_nibs(qg ^ 128'h1, 32); idle(4);
    chk("R6 bad sum flagged", 128'(sum_err), 128'd1);
    end_block();
    rdy = 1'b1; idle(3); rdy = 1'b0;
    chk("R6 sticky", 128'(sum_err), 128'd1);
    clear();
    chk("R10 sum_err cleared", 128'(sum_err), 128'd0);

    // checking off, same shape: third word is data
    chk_en = 1'b0;
    send_nibs(qe, 32); send_nibs(qf, 32); send_nibs(qg ^ 128'h1, 32); idle(4);
    chk("R7 no sum_err", 128'(sum_err), 128'd0);
    rdy = 1'b1; tick(); tick(); rdy = 1'b0;
    chk("R7 third word stored", qdata, qg ^ 128'h1);
    rdy = 1'b1; idle(2); rdy = 1'b0;
    end_block();

    // short block
    blk_len = 8'd3;
    send_nibs(qa, 32); idle(4);
    end_block();
    chk("R8 short block", 128'(len_err), 128'd1);
    rdy = 1'b1; idle(2); rdy = 1'b0;
    clear();
    chk("R10 len_err cleared", 128'(len_err), 128'd0);

    // block cut mid-word, then a full word
    send_nibs(qb, 10); idle(3);
    end_block();
    chk("R8 cut block short", 128'(len_err), 128'd1);
    send_nibs(qh, 32); idle(4);
    chk("R9 fresh alignment", qdata, qh);
    chk("R9 single word", 128'(ack), 128'd1);
    rdy = 1'b1; idle(3);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule